// File: doc/BRIEF.md
# Quarter-Rate I/Q Recovery with Decimation

This block takes a valid-qualified stream of signed 3-bit samples. The stream's band of interest has been aliased so that it sits at one quarter of the sample rate. From it the block recovers in-phase (I) and quadrature (Q) streams. At that centre frequency the cosine reference is 1, 0, -1, 0 and the sine reference is 0, 1, 0, -1. Multiplying by either one therefore reduces to three choices for each sample: pass it, negate it, or discard it. The block does this with a sign-controlled multiplexer and has no oscillator and no multipliers.

Samples taken on even mixing phases form the I stream. Samples taken on odd phases form the Q stream. As a result, each stream runs at half the accepted input rate. The I stream only passes through a delay line. The Q stream passes through a short antisymmetric FIR that approximates a 90-degree shift. The I delay equals the FIR's group delay, so the two outputs stay aligned. Both outputs appear together, qualified by a single strobe.

Top module: `fs4_iq_demod`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, valid_o is 0, and i_o and q_o are 0.
- R2: valid_o is 1 for exactly the one cycle after each clock edge that accepts a sample on an odd phase (the second sample of each pair). It is 0 in every other cycle, so it is never high on two consecutive cycles.
- R3: A cycle with valid_i low has no effect. The phase does not advance, no sample is stored, and valid_o is 0 in the next cycle.
- R4: The 2-bit phase starts at 0 after reset and advances by one on each accepted sample. Phases 0 and 1 pass the sample unchanged. Phases 2 and 3 negate it. Phases 0 and 2 feed the I stream, and phases 1 and 3 feed the Q stream.
- R5: Negation is two's complement with saturation: an input of -4 becomes +3.
- R6: When valid_o is 1, i_o equals the mixed I sample from 3 pairs before the pair just completed.
- R7: When valid_o is 1, q_o equals 3*(q[n-4]-q[n-2]) + 2*(q[n-5]-q[n-1]) + (q[n-6]-q[n]). Here q[n] is the mixed Q sample of the pair just completed, and q[n-k] is the Q sample from k pairs earlier. |q_o| never exceeds 42.
- R8: After reset, all history in both delay lines is zero. Outputs in the first pairs are computed with zeros for the samples not yet received.
- R9: i_o and q_o hold their values in every cycle in which valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| sample_i | input | S_W (3) | Signed input sample |
| valid_o | output | 1 | Output pair strobe |
| i_o | output | S_W (3) | Signed in-phase sample |
| q_o | output | Q_W (7) | Signed quadrature sample |

## Verification
The edge that accepts the second sample of a pair updates both delay lines and sets valid_o. The new i_o, q_o and strobe can therefore be observed in the cycle after that edge, one register stage after the odd-phase sample. No result depends on the cycle in which the even-phase sample arrived. The bench drives each input at a falling edge. At the next falling edge, which follows the accepting rising edge, it compares the outputs with a model that it advanced at the moment it drove the input. Each comparison therefore sees exactly one clock edge's worth of change.

// File: rtl/fs4_iq_pkg.sv
package fs4_iq_pkg;
  typedef enum logic [1:0] {
    PH_I_POS = 2'd0,
    PH_Q_POS = 2'd1,
    PH_I_NEG = 2'd2,
    PH_Q_NEG = 2'd3
  } mix_phase_e;

  localparam int unsigned HALF_TAPS = 3;
endpackage

// File: rtl/fs4_iq_mixer.sv
module fs4_iq_mixer #(
  parameter int S_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic signed [S_W-1:0] sample_i,
  output logic signed [S_W-1:0] mix_o,
  output logic                  take_i_o,
  output logic                  take_q_o
);
  import fs4_iq_pkg::*;

  localparam logic signed [S_W-1:0] S_MIN = {1'b1, {(S_W-1){1'b0}}};
  localparam logic signed [S_W-1:0] S_MAX = ~S_MIN;

  mix_phase_e phase_q;
  logic signed [S_W-1:0] neg_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= PH_I_POS;
    else if (valid_i) phase_q <= mix_phase_e'(phase_q + 2'd1);
  end

  // saturating negate: most negative code maps to most positive
  assign neg_s    = (sample_i == S_MIN) ? S_MAX : -sample_i;
  assign mix_o    = phase_q[1] ? neg_s : sample_i;
  assign take_i_o = valid_i & ~phase_q[0];
  assign take_q_o = valid_i &  phase_q[0];
endmodule

// File: rtl/fs4_iq_delay.sv
module fs4_iq_delay #(
  parameter int S_W   = 3,
  parameter int DEPTH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic signed [S_W-1:0] d_i,
  output logic signed [S_W-1:0] d_o
);
  logic signed [S_W-1:0] dl_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dl_q[0] <= '0;
    else if (shift_i) dl_q[0] <= d_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dl_q[k] <= '0;
      else if (shift_i) dl_q[k] <= dl_q[k-1];
    end
  end

  assign d_o = dl_q[DEPTH-1];
endmodule

// File: rtl/fs4_iq_hilbert.sv
module fs4_iq_hilbert #(
  parameter int S_W = 3,
  parameter int Q_W = 7,
  parameter int W1  = 3,
  parameter int W2  = 2,
  parameter int W3  = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic signed [S_W-1:0] d_i,
  output logic signed [Q_W-1:0] y_o
);
  import fs4_iq_pkg::*;

  localparam int N_TAP = 2 * HALF_TAPS + 1;
  localparam int CTR   = HALF_TAPS;
  localparam int WT [HALF_TAPS] = '{W1, W2, W3};

  logic signed [S_W-1:0] dl_q [N_TAP];
  logic signed [Q_W-1:0] part [HALF_TAPS+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dl_q[0] <= '0;
    else if (shift_i) dl_q[0] <= d_i;
  end

  for (genvar k = 1; k < N_TAP; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dl_q[k] <= '0;
      else if (shift_i) dl_q[k] <= dl_q[k-1];
    end
  end

  // antisymmetric pairs around the centre tap; the centre weight is zero
  assign part[0] = '0;
  for (genvar k = 1; k <= HALF_TAPS; k++) begin : g_pair
    logic signed [Q_W-1:0] late_s, early_s, diff_s;
    assign late_s  = Q_W'(dl_q[CTR+k]);
    assign early_s = Q_W'(dl_q[CTR-k]);
    assign diff_s  = late_s - early_s;
    assign part[k] = part[k-1] + Q_W'(WT[k-1]) * diff_s;
  end

  // the centre tap carries no weight, but it must still be read
  logic ctr_unused;
  assign ctr_unused = ^dl_q[CTR];

  assign y_o = part[HALF_TAPS];
endmodule

// File: rtl/fs4_iq_demod.sv
module fs4_iq_demod #(
  parameter int S_W = 3,
  parameter int W1  = 3,
  parameter int W2  = 2,
  parameter int W3  = 1,
  parameter int Q_W = S_W + $clog2(2 * (W1 + W2 + W3) + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic signed [S_W-1:0] sample_i,
  output logic                  valid_o,
  output logic signed [S_W-1:0] i_o,
  output logic signed [Q_W-1:0] q_o
);
  import fs4_iq_pkg::*;

  logic signed [S_W-1:0] mix_s, i_hold_q;
  logic take_i, take_q;

  fs4_iq_mixer #(.S_W(S_W)) u_mixer (
    .clk_i, .rst_ni, .valid_i, .sample_i,
    .mix_o(mix_s), .take_i_o(take_i), .take_q_o(take_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     i_hold_q <= '0;
    else if (take_i) i_hold_q <= mix_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= take_q;
  end

  // I delay matches the FIR group delay (HALF_TAPS pairs after the load stage)
  fs4_iq_delay #(.S_W(S_W), .DEPTH(HALF_TAPS + 1)) u_i_delay (
    .clk_i, .rst_ni, .shift_i(take_q), .d_i(i_hold_q), .d_o(i_o)
  );

  fs4_iq_hilbert #(.S_W(S_W), .Q_W(Q_W), .W1(W1), .W2(W2), .W3(W3)) u_q_fir (
    .clk_i, .rst_ni, .shift_i(take_q), .d_i(mix_s), .y_o(q_o)
  );
endmodule

// File: rtl/fs4_iq_demod_chk.sv
module fs4_iq_demod_chk #(
  parameter int S_W = 3,
  parameter int Q_W = 7,
  parameter int QLIM = 42
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic                  valid_o,
  input logic signed [S_W-1:0] i_o,
  input logic signed [Q_W-1:0] q_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && i_o == '0 && q_o == '0));

  p_strobe_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_idle_input_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_q_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o <= Q_W'(QLIM)) && (q_o >= -Q_W'(QLIM)));

  p_hold_outputs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_o) && $stable(q_o)));
endmodule

bind fs4_iq_demod fs4_iq_demod_chk #(.S_W(S_W), .Q_W(Q_W), .QLIM(2 * 4 * (W1 + W2 + W3) - (W1 + W2 + W3))) u_chk (
  .clk_i, .rst_ni, .valid_i, .valid_o, .i_o, .q_o
);

// File: tb/fs4_iq_demod_bench.sv
module fs4_iq_demod_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [2:0] sample_i = '0;
  logic valid_o;
  logic signed [2:0] i_o;
  logic signed [6:0] q_o;

  int n_chk = 0, n_bad = 0;
  int phase, i_hold, pairs;
  int qh [7];
  int ih [4];
  bit exp_valid;
  int exp_i, exp_q;
  string tag;

  always #5 clk = ~clk;

  fs4_iq_demod u_fs4_iq_demod (
    .clk_i(clk), .rst_ni, .valid_i, .sample_i, .valid_o, .i_o, .q_o
  );

  function automatic int mixv(int x, int ph);
    if (ph >= 2) return (x == -4) ? 3 : -x;
    return x;
  endfunction

  function automatic int fir_ref();
    return 3 * (qh[4] - qh[2]) + 2 * (qh[5] - qh[1]) + (qh[6] - qh[0]);
  endfunction

  task automatic model_clear();
    phase = 0; i_hold = 0; pairs = 0; exp_valid = 0; exp_i = 0; exp_q = 0;
    for (int k = 0; k < 7; k++) qh[k] = 0;
    for (int k = 0; k < 4; k++) ih[k] = 0;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, int s);
    @(negedge clk);
    chk(valid_o == exp_valid, {"R2 valid_o ", tag}, int'(valid_o), int'(exp_valid));
    if (exp_valid) begin
      chk(int'(i_o) == exp_i, {"R6 i_o ", tag, (pairs <= 4) ? " R8" : ""}, int'(i_o), exp_i);
      chk(int'(q_o) == exp_q, {"R7 q_o ", tag, (pairs <= 7) ? " R8" : ""}, int'(q_o), exp_q);
    end
    valid_i = v;
    sample_i = 3'(s);
    exp_valid = 0;
    if (v) begin
      int m;
      m = mixv(s, phase);
      if (phase % 2 == 0) i_hold = m;
      else begin
        for (int k = 6; k > 0; k--) qh[k] = qh[k-1];
        qh[0] = m;
        for (int k = 3; k > 0; k--) ih[k] = ih[k-1];
        ih[0] = i_hold;
        exp_valid = 1; exp_i = ih[3]; exp_q = fir_ref(); pairs++;
      end
      phase = (phase + 1) % 4;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0;
    @(negedge clk);
    chk(!valid_o && i_o == 0 && q_o == 0, "R1 reset outputs", int'(valid_o), 0);
    rst_ni = 1'b1;
    model_clear();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    tag = "R1";
    do_reset();
    step(0, 0);
    // R4: ramp of known positive values through all four phases
    tag = "R4";
    for (int k = 0; k < 16; k++) step(1, (k % 4));
    // R5: most negative input, negated on phases 2 and 3
    tag = "R5";
    for (int k = 0; k < 16; k++) step(1, -4);
    for (int k = 0; k < 8; k++) step(1, 3);
    // R3: gaps between samples must not shift phase
    tag = "R3";
    for (int k = 0; k < 24; k++) begin
      step(1, (k * 3) % 8 - 4);
      step(0, 2);
      step(0, -3);
    end
    // R1/R8: reset mid-stream, history must restart from zero
    tag = "R8";
    do_reset();
    for (int k = 0; k < 20; k++) step(1, -4 + (k % 8));
    // random traffic
    tag = "R9";
    for (int k = 0; k < 3000; k++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, int'($urandom % 8) - 4);
    end
    step(0, 0);
    step(0, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule